// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is an SPI mode-0 slave that behaves like a small serial EEPROM. It holds a 256-byte array and a status register, and it runs entirely on a system clock. Chip select, serial clock and serial data in are synchronised into that clock domain. Each rising serial-clock edge shifts one bit in, most significant bit first. Each falling edge presents the next output bit. A transaction begins when chip select falls and ends when it rises.

Chip-select timing decides what a command does. Reads and status reads stop at any point and leave no trace. Write-type commands are dropped unless at least one complete data byte has arrived. Once such a byte is in, raising chip select starts a self-timed write cycle that cannot be stopped. Write enable and write disable act on the final opcode bit. While the write cycle runs, only status polling is served. The poll returns the old status contents with both low flags set.

The controller has seven states: IDLE, OPCODE, ADDR, WDATA, RDOUT, STOUT and SKIP. Chip select high forces IDLE, and chip select low moves IDLE to OPCODE. When the opcode byte completes, OPCODE goes to one of four states:
- ADDR for a read, or for a write or page write while enabled.
- WDATA for a status write while enabled.
- STOUT for a status read.
- SKIP for anything else. This covers write enable, write disable, unknown codes, writes without enable, and every command except status read during a write cycle.

When the address byte completes, ADDR goes to RDOUT for a read and to WDATA for a write. RDOUT, STOUT, WDATA and SKIP hold until chip select rises.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Opcode, address and data bytes are 8 bits, transferred MSB first. The opcodes are 0x01 status write, 0x02 write, 0x03 read, 0x04 write disable, 0x05 status read, 0x06 write enable and 0x0A page write. A read returns the byte at the address, then the following addresses, wrapping from 0xFF to 0x00.
- R2: spi_miso_oe is 0 whenever chip select is high and 1 while it is low. spi_miso changes only after falling serial-clock edges, so it is stable when the master samples on the rising edge.
- R3: Raising chip select at any point of a read or status read ends it without changing memory, status or the enable latch.
- R4: A write, page write or status write is discarded when chip select rises before its first data byte is complete. An incomplete trailing data byte is dropped.
- R5: Raising chip select after at least one complete data byte starts a write cycle lasting WCYC system clocks. The cycle cannot be cancelled, and the stored data appears only when it ends.
- R6: The status byte has busy in bit 0, the enable latch in bit 1 and user bits in bits 7:2. During a write cycle it reads the pre-write user bits with bits 1:0 = 11.
- R7: A status write changes only bits 7:2, and only when its write cycle completes.
- R8: The enable latch is cleared when a write cycle completes.
- R9: Write enable sets the latch and write disable clears it, at the 8th rising serial-clock edge. Raising chip select before that edge cancels the command.
- R10: Write commands are ignored while the enable latch is clear.
- R11: During a write cycle every command except status read is ignored.
- R12: Page write stores consecutive bytes, incrementing the low 4 address bits and wrapping within a 16-byte page. A plain write stores only its first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_clk | input | 1 | Serial clock from master |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |

## Verification
An off-by-one bit counter or a wrong state transition shows within one transaction: a read returns shifted or wrong bytes. A status poll at the next chip-select cycle reveals a wrong latch or busy flag, because the enable and busy bits are visible there. A write-commit or cancellation error stays hidden until the write cycle ends. It then appears on the first read-back of the touched address or status bits. For that reason every write in the bench is followed by a busy poll, a ready wait and a read-back.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BW = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_OPCODE, S_ADDR, S_WDATA, S_RDOUT, S_STOUT, S_SKIP
    } eep_state_t;

    localparam logic [BW-1:0] OP_WRSR = 8'h01;
    localparam logic [BW-1:0] OP_WRITE = 8'h02;
    localparam logic [BW-1:0] OP_READ = 8'h03;
    localparam logic [BW-1:0] OP_WRDI = 8'h04;
    localparam logic [BW-1:0] OP_RDSR = 8'h05;
    localparam logic [BW-1:0] OP_WREN = 8'h06;
    localparam logic [BW-1:0] OP_PGWR = 8'h0A;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] s1, s2, s3;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1[g] <= RST[g];
                s2[g] <= RST[g];
                s3[g] <= RST[g];
            end else begin
                s1[g] <= d_in[g];
                s2[g] <= s1[g];
                s3[g] <= s2[g];
            end
        end
    end

    assign q      = s2;
    assign q_prev = s3;
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int WCYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WCYC + 1);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(WCYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the cycle always runs its full length
    p_cycle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cnt) == CW'(WCYC - 1));
    // R11: no new write cycle is requested while one runs
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import eep_pkg::*;
#(
    parameter int AW      = 8,
    parameter int PAGE_AW = 4,
    parameter int WCYC    = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_clk,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PAGE_AW;
    localparam int HW    = AW - PAGE_AW;

    logic [2:0] sq, sp;
    eep_sync #(.W(3), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({spi_cs_n, spi_clk, spi_mosi}),
        .q(sq), .q_prev(sp)
    );

    logic cs_q, cs_fall, cs_rise, sck_rise, sck_fall, mosi_q;
    assign cs_q     = sq[2];
    assign cs_fall  = !sq[2] && sp[2];
    assign cs_rise  = sq[2] && !sp[2];
    assign sck_rise = !cs_q && sq[1] && !sp[1];
    assign sck_fall = !cs_q && !sq[1] && sp[1];
    assign mosi_q   = sq[0];

    eep_state_t       state, nxt;
    logic [2:0]       bcnt;
    logic [BW-1:0]    rx, op, tx, sr_pend;
    logic [BW-1:0]    rx_next;
    logic [AW-1:0]    addr, wptr;
    logic [HW-1:0]    wr_page;
    logic             wel, got_byte, wr_kind, miso_r, byte_done;
    logic [BW-3:0]    sreg_u;
    logic [BW-1:0]    pbuf [PAGE];
    logic [PAGE-1:0]  pmask;
    logic [BW-1:0]    mem [DEPTH];
    logic             busy, wdone, wstart;
    logic [BW-1:0]    status_view;

    assign rx_next     = {rx[BW-2:0], mosi_q};
    assign byte_done   = sck_rise && (bcnt == 3'd7);
    assign status_view = {sreg_u, wel, busy};
    assign wstart      = cs_rise && (state == S_WDATA) && got_byte;

    eep_wtimer #(.WCYC(WCYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wstart), .busy(busy), .done(wdone)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_q) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: nxt = S_OPCODE;
                S_OPCODE: if (byte_done) begin
                    if (busy && rx_next != OP_RDSR) nxt = S_SKIP;
                    else if (rx_next == OP_READ) nxt = S_ADDR;
                    else if (rx_next == OP_RDSR) nxt = S_STOUT;
                    else if ((rx_next == OP_WRITE || rx_next == OP_PGWR) && wel) nxt = S_ADDR;
                    else if (rx_next == OP_WRSR && wel) nxt = S_WDATA;
                    else nxt = S_SKIP;
                end
                S_ADDR: if (byte_done) nxt = (op == OP_READ) ? S_RDOUT : S_WDATA;
                S_WDATA, S_RDOUT, S_STOUT, S_SKIP: nxt = state;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0; rx <= '0; op <= '0; tx <= '0; sr_pend <= '0;
            addr <= '0; wptr <= '0; wr_page <= '0; wel <= 1'b0;
            got_byte <= 1'b0; wr_kind <= 1'b0; miso_r <= 1'b0;
            sreg_u <= '0; pmask <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (cs_q) bcnt <= '0;
            else if (sck_rise) begin
                bcnt <= bcnt + 1'b1;
                rx   <= rx_next;
            end
            if (cs_fall) begin
                got_byte <= 1'b0;
                if (!busy) pmask <= '0;
            end
            if (byte_done) begin
                unique case (state)
                    S_OPCODE: begin
                        op <= rx_next;
                        if (!busy && rx_next == OP_WREN) wel <= 1'b1;
                        if (!busy && rx_next == OP_WRDI) wel <= 1'b0;
                        if (rx_next == OP_RDSR) tx <= status_view;
                    end
                    S_ADDR: begin
                        addr <= rx_next;
                        wptr <= rx_next;
                        tx   <= mem[rx_next];
                    end
                    S_WDATA: begin
                        got_byte <= 1'b1;
                        if (op == OP_WRSR) begin
                            if (!got_byte) sr_pend <= rx_next;
                        end else if (op == OP_PGWR || !got_byte) begin
                            pbuf[wptr[PAGE_AW-1:0]]  <= rx_next;
                            pmask[wptr[PAGE_AW-1:0]] <= 1'b1;
                            wptr[PAGE_AW-1:0]        <= wptr[PAGE_AW-1:0] + 1'b1;
                        end
                    end
                    S_RDOUT: begin
                        addr <= addr + 1'b1;
                        tx   <= mem[addr + 1'b1];
                    end
                    S_STOUT: tx <= status_view;
                    default: ;
                endcase
            end
            if (sck_fall) begin
                miso_r <= tx[BW-1];
                tx     <= {tx[BW-2:0], 1'b0};
            end
            if (wstart) begin
                wr_kind <= (op == OP_WRSR);
                wr_page <= wptr[AW-1:PAGE_AW];
            end
            if (wdone) begin
                wel <= 1'b0;
                if (wr_kind) sreg_u <= sr_pend[BW-1:2];
                else begin
                    for (int i = 0; i < PAGE; i++)
                        if (pmask[i]) mem[{wr_page, PAGE_AW'(i)}] <= pbuf[i];
                end
            end
        end
    end

    assign spi_miso    = miso_r;
    assign spi_miso_oe = !cs_q;

    // R8: latch is clear once a write cycle has ended
    p_wel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    // R9: latch only rises on an opcode byte
    p_wel_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(state) == S_OPCODE);
    // R7: user status bits frozen while the cycle runs
    p_sreg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wdone) |=> $stable(sreg_u));
    // R4: a write cycle never starts from a transaction without data
    p_start_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(got_byte));
endmodule

// File: tb/sim_spi_eeprom_ctrl.sv
module sim_spi_eeprom_ctrl;
    localparam int WCYC = 600;
    localparam int HP   = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;

    always #4 clk = ~clk;

    spi_eeprom_ctrl #(.AW(8), .PAGE_AW(4), .WCYC(WCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_clk(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem_m [256];
    logic [5:0] sr_m = '0;
    logic       wel_m = 1'b0;
    logic [7:0] wbuf [16];

    function automatic logic [7:0] stat_exp(input logic b);
        return {sr_m, (b ? 1'b1 : wel_m), b};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic bits(input logic [7:0] t, input int nb, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = t[i];
            #HP;
            r[i] = miso;
            sck = 1'b1;
            #HP;
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        bits(t, 8, r);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        #HP;
    endtask

    task automatic desel();
        #HP;
        cs_n = 1'b1;
        #(HP * 2);
    endtask

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h05, d); xfer(8'h00, v); desel();
    endtask

    task automatic cmd1(input logic [7:0] c);
        logic [7:0] d;
        sel(); xfer(c, d); desel();
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int k = 0; k < 40; k++) begin
            rdsr(v);
            if (!v[0]) break;
        end
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input int n);
        logic [7:0] d;
        sel(); xfer(8'h03, d); xfer(a, d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            check(req, d, mem_m[8'(a + k)]);
        end
        desel();
    endtask

    // writes n bytes of wbuf, optional partial trailing bits, then follows the cycle
    task automatic do_write(input string req, input logic [7:0] op, input logic [7:0] a,
                            input int n, input int cut);
        logic [7:0] d;
        logic commit;
        logic [7:0] v;
        commit = wel_m && (n >= 1);
        sel(); xfer(op, d);
        if (op != 8'h01) xfer(a, d);
        for (int k = 0; k < n; k++) xfer(wbuf[k], d);
        if (cut > 0) bits(8'h5A, cut, d);
        desel();
        if (commit) begin
            rdsr(v);
            check(req, v, stat_exp(1'b1));
            wait_ready();
            if (op == 8'h01) sr_m = wbuf[0][7:2];
            else if (op == 8'h0A)
                for (int k = 0; k < n; k++) mem_m[{a[7:4], 4'(a[3:0] + k)}] = wbuf[k];
            else mem_m[a] = wbuf[0];
            wel_m = 1'b0;
        end
        rdsr(v);
        check(req, v, stat_exp(1'b0));
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_all();
    end

    initial begin
        logic [7:0] v, d;
        int unsigned s;
        s = $urandom(32'd77);
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        #96; rst_n = 1'b1; #96;

        // R2 reset and idle state
        check("R2 oe idle", {7'd0, miso_oe}, 8'h00);
        rdsr(v); check("R6 reset status", v, 8'h00);
        sel(); check("R2 oe selected", {7'd0, miso_oe}, 8'h01); desel();

        // R9 enable/disable and cancellation
        cmd1(8'h06); wel_m = 1'b1;
        rdsr(v); check("R9 wren", v, stat_exp(1'b0));
        sel(); bits(8'h04, 7, d); desel();
        rdsr(v); check("R9 wrdi cancelled", v, stat_exp(1'b0));
        cmd1(8'h04); wel_m = 1'b0;
        rdsr(v); check("R9 wrdi", v, stat_exp(1'b0));
        sel(); bits(8'h06, 7, d); desel();
        rdsr(v); check("R9 wren cancelled", v, stat_exp(1'b0));

        // R10 write without enable ignored
        wbuf[0] = 8'hA5;
        do_write("R10 no wel", 8'h02, 8'h20, 1, 0);
        read_chk("R10 readback", 8'h20, 1);

        // R5 plain write, busy poll, readback; R12 plain write keeps first byte
        cmd1(8'h06); wel_m = 1'b1;
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        do_write("R5 write", 8'h02, 8'h40, 2, 0);
        read_chk("R12 plain write", 8'h40, 2);

        // R12 page write wrap within page
        cmd1(8'h06); wel_m = 1'b1;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write("R12 page", 8'h0A, 8'h1E, 4, 0);
        read_chk("R12 page wrap", 8'h10, 16);

        // R4 cancel inside data byte, and trailing partial byte dropped
        cmd1(8'h06); wel_m = 1'b1;
        wbuf[0] = 8'h77;
        do_write("R4 cancel", 8'h02, 8'h40, 0, 5);
        read_chk("R4 unchanged", 8'h40, 1);
        wbuf[0] = 8'h99;
        do_write("R4 partial tail", 8'h0A, 8'h50, 1, 6);
        read_chk("R4 tail dropped", 8'h50, 2);

        // R6 R7 R8 status write: 0C, then 00 with busy view
        cmd1(8'h06); wel_m = 1'b1;
        wbuf[0] = 8'h0F;
        do_write("R7 wrsr", 8'h01, 8'h00, 1, 0);
        rdsr(v); check("R7 low bits untouched", v, 8'h0C);
        cmd1(8'h06); wel_m = 1'b1;
        rdsr(v); check("R6 before", v, 8'h0E);
        wbuf[0] = 8'h00;
        do_write("R6 busy view", 8'h01, 8'h00, 1, 0);
        rdsr(v); check("R8 wel cleared", v, 8'h00);

        // R11 write during busy ignored
        cmd1(8'h06); wel_m = 1'b1;
        wbuf[0] = 8'hE1;
        sel(); xfer(8'h02, d); xfer(8'h60, d); xfer(wbuf[0], d); desel();
        sel(); xfer(8'h02, d); xfer(8'h61, d); xfer(8'hBB, d); desel();
        wait_ready(); mem_m[8'h60] = 8'hE1; wel_m = 1'b0;
        read_chk("R11 busy ignore", 8'h60, 2);

        // R3 read and status-read cancel
        sel(); xfer(8'h03, d); bits(8'h60, 4, d); desel();
        sel(); xfer(8'h05, d); bits(8'h00, 3, d); desel();
        rdsr(v); check("R3 no side effect", v, stat_exp(1'b0));
        read_chk("R3 read after cancel", 8'h60, 1);

        // R1 sequential read wrapping past 0xFF
        mem_m[8'hFF] = 8'h00;
        read_chk("R1 wrap read", 8'hFE, 4);

        // random writes mixed with cancellations
        for (int it = 0; it < 30; it++) begin
            logic [7:0] a;
            int n, cut;
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            cut = ($urandom % 4 == 0) ? 1 + int'($urandom % 7) : 0;
            for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom);
            if ($urandom % 5 != 0) begin cmd1(8'h06); wel_m = 1'b1; end
            if (cut > 0 && ($urandom % 2 == 0)) n = 0;
            do_write("R5 random", ($urandom % 2 == 0) ? 8'h0A : 8'h02, a, n, cut);
            read_chk("R1 random readback", {a[7:4], 4'h0}, 16);
        end

        finish_all();
    end
endmodule